// File: doc/BRIEF.md
# SPI Converter Target Emulator

This block stands in for a small serial analog-to-digital converter on an SPI bus. A host SPI reader can then be tested against it without a real converter. It watches an active-low chip select, the serial clock and the host-to-target data line, all running in SPI mode 0. It decodes a bit-serial command made of a start bit, a mode flag and a three-bit channel number. It then answers on the target-to-host line with a zero bit, a null bit and the ten bits of the chosen sample, most significant bit first.

The sample values come from eight parallel 10-bit inputs, one per channel. The channel number in the command picks one of them. The whole block runs on a fast system clock. The bus pins are oversampled through synchronizers, and the serial clock edges are found in the system clock domain. The output line has a separate enable, so that its high-impedance state while the target is deselected can be modelled.

Top module: `adc_spi_emu`

## Requirements
- R1: After reset, miso_oe_o is 0 and miso_o is 0.
- R2: The first 1 sampled on MOSI at a rising SCLK edge with chip select low is taken as the start bit. Any number of 0 bits before it is ignored.
- R3: The bit after the start bit is the mode flag (1 = single-ended, 0 = differential). The next three bits are the channel number, most significant first. Channel c returns samples_i[c*10 +: 10], and 000 selects channel 0.
- R4: After the rising edge that completes the channel field, the target drives MISO from the following falling edge onward. That first driven bit is 0, the next falling edge presents the null bit (0), and the ten result bits follow MSB first, one per falling edge. In the usual three-byte framing (start bit in the LSB of byte 1, mode flag in the MSB of byte 2), the null bit is bit 2 of returned byte 2, result bits 9..8 are bits 1..0 of that byte, and bits 7..0 form returned byte 3.
- R5: In differential mode the word returned is the selected sample input, unchanged.
- R6: The selected sample is captured at the clock that completes the channel field. Changes on samples_i after that point do not alter the word being shifted out.
- R7: Clock edges after the least significant result bit shift out 0 until chip select rises.
- R8: miso_oe_o is 0, and miso_o is 0, while chip select is high. miso_oe_o also stays 0 during the command bits, until the first falling edge after the channel field.
- R9: Raising chip select at any point aborts the transaction. The next transaction is decoded from a fresh start-bit search.
- R10: SCLK, MOSI and chip select each pass through a two-flop synchronizer. An SCLK as fast as one quarter of the system clock is decoded. MISO settles within three system clocks of a falling SCLK edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select from the host, active low |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| mosi_i | input | 1 | Command data from the host, sampled on rising SCLK |
| samples_i | input | 80 | Eight 10-bit sample values, channel c at bits c*10+9..c*10 |
| miso_o | output | 1 | Response data to the host, changes after falling SCLK |
| miso_oe_o | output | 1 | High while the target drives miso_o |

## Verification
Two events can reach the control logic in the same system clock cycle. One is the deselect that aborts a transaction; the other is a falling SCLK edge that would shift the next response bit. The bench provokes this by lowering SCLK and raising chip select at the same instant in the middle of the result. Both then pass through equal-depth synchronizers and arrive together. The outcome is judged correct if the output enable drops with no extra shift, and if the very next transaction returns its channel's word bit for bit against the bench's model.

// File: rtl/adc_emu_pkg.sv
// Shared types for the SPI converter target emulator.
package adc_emu_pkg;
    // Frame decoder phases: search for start, mode flag, channel field, response.
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_MODE = 2'd1,
        ST_CHAN = 2'd2,
        ST_SEND = 2'd3
    } frame_st_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Two-flop synchronizer for a group of asynchronous bus pins.
// Assumes each pin holds a level for at least two system clocks.
// All bits share the same depth, so pins stay aligned with each other.
module spi_pin_sync #(
    parameter int           N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] stab_q;

    // Two-stage capture of the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= pins_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/sclk_edge_det.sv
// Finds rising and falling edges of the synchronized serial clock.
// Assumes the input is already in the system clock domain; each edge gives a one-cycle pulse.
module sclk_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/adc_chan_mux.sv
// Selects one sample word from the flat vector of channel inputs.
// Assumes the flat vector packs channel c at bits c*W+W-1 .. c*W.
module adc_chan_mux #(
    parameter int W       = 10,
    parameter int CH_BITS = 3,
    localparam int NCH    = 1 << CH_BITS
) (
    input  logic [NCH*W-1:0]   samples_i,
    input  logic [CH_BITS-1:0] sel_i,
    output logic [W-1:0]       word_o
);
    logic [W-1:0] words [NCH];

    // Split the flat vector into one word per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_split
        assign words[g] = samples_i[g*W +: W];
    end

    assign word_o = words[sel_i];
endmodule

// File: rtl/adc_frame_ctrl.sv
// Command decoder and response shifter for the converter target.
// Assumes single-cycle rise/fall pulses and a deselect that is already synchronized.
// A deselect takes priority over any edge that arrives in the same cycle.
module adc_frame_ctrl
    import adc_emu_pkg::*;
#(
    parameter int W        = 10,
    parameter int CH_BITS  = 3,
    localparam int SW      = W + 2,
    localparam int CNTW    = $clog2(CH_BITS) < 1 ? 1 : $clog2(CH_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               mosi_i,
    input  logic [W-1:0]       word_i,
    output logic [CH_BITS-1:0] ch_o,
    output logic               miso_o,
    output logic               oe_o
);
    frame_st_t          st_q;
    logic [CH_BITS-2:0] ch_q;
    logic [CNTW-1:0]    cnt_q;
    logic [SW-1:0]      shreg_q;
    logic               miso_q;
    logic               oe_q;

    // Channel number including the bit currently on MOSI.
    assign ch_o = {ch_q, mosi_i};

    // Command decode on rising edges, response shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_HUNT;
            ch_q    <= '0;
            cnt_q   <= '0;
            shreg_q <= '0;
            miso_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (!sel_i) begin
            st_q    <= ST_HUNT;
            cnt_q   <= '0;
            miso_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            if (rise_i) begin
                case (st_q)
                    ST_HUNT: if (mosi_i) st_q <= ST_MODE;
                    ST_MODE: begin
                        st_q  <= ST_CHAN;
                        cnt_q <= '0;
                    end
                    ST_CHAN: begin
                        ch_q  <= ch_o[CH_BITS-2:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNTW'(CH_BITS - 1)) begin
                            st_q    <= ST_SEND;
                            shreg_q <= {2'b00, word_i};
                        end
                    end
                    default: ;
                endcase
            end
            if (fall_i && st_q == ST_SEND) begin
                miso_q  <= shreg_q[SW-1];
                shreg_q <= {shreg_q[SW-2:0], 1'b0};
                oe_q    <= 1'b1;
            end
        end
    end

    assign miso_o = miso_q;
    assign oe_o   = oe_q;

    AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !oe_o); // R8
    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> !miso_o); // R8
    AST_OE_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> st_q == ST_SEND); // R4
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && sel_i && !fall_i) |=> $stable(shreg_q)); // R6
    AST_START_ENTERS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && rise_i && mosi_i && st_q == ST_HUNT) |=> st_q == ST_MODE); // R2
    AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> st_q == ST_HUNT); // R9
endmodule

// File: rtl/adc_spi_emu.sv
// SPI mode-0 target that emulates an eight-channel 10-bit converter.
// Assumes the system clock runs at least four times faster than SCLK.
// Bus pins are synchronized together so that MOSI and chip select stay aligned with SCLK.
module adc_spi_emu #(
    parameter int SMP_W   = 10,
    parameter int CH_BITS = 3,
    localparam int NCH    = 1 << CH_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_i,
    input  logic               sclk_i,
    input  logic               mosi_i,
    input  logic [NCH*SMP_W-1:0] samples_i,
    output logic               miso_o,
    output logic               miso_oe_o
);
    logic [2:0]         pins_s;
    logic               sclk_rise;
    logic               sclk_fall;
    logic [CH_BITS-1:0] ch_sel;
    logic [SMP_W-1:0]   ch_word;

    // Bit 2 chip select (idles high), bit 1 MOSI, bit 0 SCLK.
    spi_pin_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({cs_n_i, mosi_i, sclk_i}),
        .sync_o (pins_s)
    );

    sclk_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pins_s[0]),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    adc_chan_mux #(.W(SMP_W), .CH_BITS(CH_BITS)) u_mux (
        .samples_i (samples_i),
        .sel_i     (ch_sel),
        .word_o    (ch_word)
    );

    adc_frame_ctrl #(.W(SMP_W), .CH_BITS(CH_BITS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (~pins_s[2]),
        .rise_i (sclk_rise),
        .fall_i (sclk_fall),
        .mosi_i (pins_s[1]),
        .word_i (ch_word),
        .ch_o   (ch_sel),
        .miso_o (miso_o),
        .oe_o   (miso_oe_o)
    );
endmodule

// File: tb/sim_adc_spi_emu.sv
// Bench: a behavioural host plus a bit-level model of the expected reply, checked on every SCLK bit.
module sim_adc_spi_emu;
    localparam int W   = 10;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic [NCH*W-1:0] samples;
    logic miso;
    logic miso_oe;

    int checks = 0;
    int fails = 0;
    int hi_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_spi_emu #(.SMP_W(W), .CH_BITS(3)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n),
        .sclk_i    (sclk),
        .mosi_i    (mosi),
        .samples_i (samples),
        .miso_o    (miso),
        .miso_oe_o (miso_oe)
    );

    function automatic logic [W-1:0] smp(input int c);
        return samples[c*W +: W];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock model check: a deselected target never drives the line (R8).
    always @(negedge clk) begin
        if (cs_n) hi_cnt++;
        else      hi_cnt = 0;
        if (rst_n && !done && hi_cnt >= 4) chk("R8 idle oe", {31'd0, miso_oe}, 32'd0);
    end

    // One host transaction; nb bits of pat sent MSB first.
    task automatic xact(input string tg, input int nb, input logic [31:0] pat,
                        input int abort_at, input int chg_at,
                        input logic [NCH*W-1:0] newsmp, input int lo, input int hi);
        int st = 0;
        int cc = 0;
        int ch = 0;
        int k = 0;
        logic [W-1:0] val = '0;
        logic b;
        logic e;
        string t;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            b = pat[nb-1-i];
            mosi = b;
            repeat (lo) @(negedge clk);
            if (st == 3) begin
                e = (k >= 3 && k <= 12) ? val[12-k] : 1'b0;
                t = (k > 12) ? "R7" : ((k <= 2) ? "R4" : tg);
                chk({t, " oe"}, {31'd0, miso_oe}, 32'd1);
                chk({t, " miso"}, {31'd0, miso}, {31'd0, e});
                k++;
            end else begin
                chk("R8 cmd oe", {31'd0, miso_oe}, 32'd0);
            end
            sclk = 1'b1;
            case (st)
                0: if (b) st = 1;
                1: begin st = 2; cc = 0; ch = 0; end
                2: begin
                    ch = ch * 2 + int'(b);
                    cc++;
                    if (cc == 3) begin val = smp(ch); st = 3; k = 1; end
                end
                default: ;
            endcase
            repeat (hi) @(negedge clk);
            if (i == abort_at) begin
                sclk = 1'b0;
                cs_n = 1'b1;
                mosi = 1'b0;
                repeat (8) @(negedge clk);
                chk("R9 abort oe", {31'd0, miso_oe}, 32'd0);
                return;
            end
            if (i == chg_at) samples = newsmp;
            sclk = 1'b0;
        end
        repeat (lo) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 end oe", {31'd0, miso_oe}, 32'd0);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) samples[c*W +: W] = W'((c * 'h93 + 'h155) & 'h3FF);
        samples[0 +: W] = 10'h2A5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 oe", {31'd0, miso_oe}, 32'd0);
        chk("R1 miso", {31'd0, miso}, 32'd0);
        xact("R3", 24, 32'h018000, -1, -1, '0, 4, 4);
        xact("R3", 24, 32'h01D000, -1, -1, '0, 4, 4);
        xact("R5", 24, 32'h013000, -1, -1, '0, 4, 4);
        xact("R2", 24, 32'h1F0000, -1, -1, '0, 4, 4);
        xact("R6", 24, 32'h01E000, -1, 11, ~samples, 4, 4);
        xact("R9", 24, 32'h01A000, 18, -1, '0, 4, 4);
        xact("R9", 24, 32'h01A000, -1, -1, '0, 4, 4);
        xact("R9", 24, 32'h01C000, 9, -1, '0, 4, 4);
        xact("R9", 24, 32'h01C000, -1, -1, '0, 4, 4);
        xact("R10", 24, 32'h019000, -1, -1, '0, 3, 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        checks++;
        fails++;
        done = 1'b1;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule